// File: doc/BRIEF.md
# Stack-Operand Memory AND Unit

This block carries out the read-modify-write half of three memory AND instructions for a 16-bit processor whose operands live on a register stack. The execute stage presents the top three stack registers (A on top, then B, then C), a two-bit operation code and the current privilege mode. The unit reads one memory word and ANDs it with a stack word. It writes the result back to the same location, reports how many stack entries the instruction consumed, and updates a two-bit condition code from the stored result.

There are three operation codes. The first targets the current data segment: A is the word address and B is the data. The second targets the system data segment in the same way, but only in privileged mode. The third targets extended memory: B:A (B in the high half) is a 32-bit byte address that must be even, and C is the data. A broken rule produces a one-cycle trap pulse with a cause code. In that case there is no memory traffic, no pop and no condition-code change.

The controller is a single state machine. Its states are IDLE, READ, WAIT, WRITE, FINISH and TRAP. Its transitions are accept (IDLE to READ), reject (IDLE to TRAP), read-issued (READ to WAIT), data-captured (WAIT to WRITE), write-issued (WRITE to FINISH), retire (FINISH to IDLE) and trap-retire (TRAP to IDLE). Any other IDLE cycle stays in IDLE.

Top module: `stkmem_and_unit`

## Requirements
- R1: With operation code 0, the unit reads the word at address A (zero-extended, space code 0 = data segment). It writes B AND that word back to the same address and reports a pop count of 2 with done.
- R2: With operation code 1 and priv_mode high, the unit does the same as R1 in space code 1 (system segment) and reports a pop count of 2.
- R3: With operation code 1 and priv_mode low, trap pulses for one cycle, one clock after acceptance, with trap_code 1. No memory request is made, done stays low and the condition code is held.
- R4: With operation code 2 and an even address, the unit uses byte address {B,A} in space code 2. It writes C AND the memory word and reports a pop count of 3.
- R5: With operation code 2 and A bit 0 set, trap pulses with trap_code 2. No memory request is made and the condition code is held.
- R6: When done is high, cc_n equals bit 15 of the written result and cc_z is high exactly when that result is zero. At all other times the condition code holds its value.
- R7: After acceptance the unit makes a read request (mem_req=1, mem_we=0) in the next cycle and leaves mem_req low in the cycle after that. It makes the write request in the cycle after that and pulses done in the cycle after the write, so done comes 4 cycles after acceptance.
- R8: busy is high from the cycle after acceptance through the done or trap cycle. cmd_valid is ignored while busy is high.
- R9: Operation code 3 is ignored: busy stays low and no memory request or trap follows.
- R10: After reset the unit is idle: busy, done, trap and mem_req are low, pop_cnt is 0 and the condition code is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, sampled while not busy |
| cmd_op | input | 2 | 0 data segment, 1 system segment, 2 extended, 3 none |
| priv_mode | input | 1 | High when executing in privileged mode |
| stk_a | input | 16 | Top stack register A |
| stk_b | input | 16 | Stack register B |
| stk_c | input | 16 | Stack register C |
| busy | output | 1 | Operation in progress |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | High for a write request |
| mem_space | output | 2 | 0 data, 1 system, 2 extended |
| mem_addr | output | 32 | Word address (spaces 0, 1) or byte address (space 2) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| done | output | 1 | One-cycle completion pulse |
| pop_cnt | output | 2 | Stack entries to pop, valid with done, else 0 |
| trap | output | 1 | One-cycle trap pulse |
| trap_code | output | 2 | 1 privilege, 2 alignment, valid with trap, else 0 |
| cc_n | output | 1 | Condition code negative flag |
| cc_z | output | 1 | Condition code zero flag |

## Verification
The AND path is run with result patterns that are negative, zero and positive, so each condition-code flag is seen both set and clear. Some patterns put ones in the stack word and zeros in memory and others do the reverse; this separates a true AND from an OR or a plain copy of either operand. Extended addresses with a nonzero B half show whether the high address half is formed from B and whether the word index is taken from the byte address. The two trap cases are run right after completed operations, so a held condition code and untouched memory can be told apart from a partial update.

// File: rtl/stkand_pkg.sv
package stkand_pkg;
    typedef enum logic [1:0] {
        OP_DSEG = 2'd0,
        OP_SSEG = 2'd1,
        OP_XMEM = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        SP_DATA = 2'd0,
        SP_SYS  = 2'd1,
        SP_EXT  = 2'd2,
        SP_RSVD = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        TRAP_NONE  = 2'd0,
        TRAP_PRIV  = 2'd1,
        TRAP_ALIGN = 2'd2,
        TRAP_RSVD  = 2'd3
    } trap_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_READ   = 3'd1,
        ST_WAIT   = 3'd2,
        ST_WRITE  = 3'd3,
        ST_FINISH = 3'd4,
        ST_TRAP   = 3'd5
    } state_e;
endpackage

// File: rtl/stkand_decode.sv
module stkand_decode
    import stkand_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic [1:0]        op,
    input  logic              priv,
    input  logic [WORD_W-1:0] reg_a,
    input  logic [WORD_W-1:0] reg_b,
    input  logic [WORD_W-1:0] reg_c,
    output logic              legal,
    output trap_e             trap_cause,
    output space_e            space,
    output logic [ADDR_W-1:0] addr,
    output logic [WORD_W-1:0] operand,
    output logic [1:0]        pops
);
    localparam int PAIR_W = 2 * WORD_W;

    logic [PAIR_W-1:0] pair_addr;
    logic [ADDR_W-1:0] short_addr;
    logic [ADDR_W-1:0] long_addr;

    assign pair_addr = {reg_b, reg_a};

    generate
        if (ADDR_W >= PAIR_W) begin : g_wide
            assign long_addr  = {{(ADDR_W-PAIR_W){1'b0}}, pair_addr};
            assign short_addr = {{(ADDR_W-WORD_W){1'b0}}, reg_a};
        end else begin : g_narrow
            assign long_addr  = pair_addr[ADDR_W-1:0];
            assign short_addr = (ADDR_W >= WORD_W) ? ADDR_W'(reg_a) : reg_a[ADDR_W-1:0];
        end
    endgenerate

    always_comb begin
        legal      = 1'b1;
        trap_cause = TRAP_NONE;
        space      = SP_DATA;
        addr       = short_addr;
        operand    = reg_b;
        pops       = 2'd2;
        unique case (op_e'(op))
            OP_DSEG: begin
                space = SP_DATA;
            end
            OP_SSEG: begin
                space = SP_SYS;
                if (!priv) trap_cause = TRAP_PRIV;
            end
            OP_XMEM: begin
                space   = SP_EXT;
                addr    = long_addr;
                operand = reg_c;
                pops    = 2'd3;
                if (reg_a[0]) trap_cause = TRAP_ALIGN;
            end
            default: begin
                legal = 1'b0;
                pops  = 2'd0;
            end
        endcase
    end
endmodule

// File: rtl/stkand_fsm.sv
module stkand_fsm
    import stkand_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  cmd_valid,
    input  logic  cmd_legal,
    input  trap_e trap_cause,
    output logic  busy,
    output logic  load_cmd,
    output logic  load_rdata,
    output logic  commit,
    output logic  mem_req,
    output logic  mem_we,
    output logic  done,
    output logic  trap
);
    state_e state_q;
    state_e state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d    = state_q;
        busy       = 1'b1;
        load_cmd   = 1'b0;
        load_rdata = 1'b0;
        commit     = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        done       = 1'b0;
        trap       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                if (cmd_valid && cmd_legal) begin
                    load_cmd = 1'b1;
                    state_d  = (trap_cause != TRAP_NONE) ? ST_TRAP : ST_READ;
                end
            end
            ST_READ: begin
                mem_req = 1'b1;
                state_d = ST_WAIT;
            end
            ST_WAIT: begin
                load_rdata = 1'b1;
                state_d    = ST_WRITE;
            end
            ST_WRITE: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                commit  = 1'b1;
                state_d = ST_FINISH;
            end
            ST_FINISH: begin
                done    = 1'b1;
                state_d = ST_IDLE;
            end
            ST_TRAP: begin
                trap    = 1'b1;
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // R7
    rd_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);
    // R7
    wr_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> done);
    // R3
    trap_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap |-> (!mem_req && !done));
endmodule

// File: rtl/stkand_datapath.sv
module stkand_datapath
    import stkand_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_cmd,
    input  logic              load_rdata,
    input  logic              commit,
    input  space_e            space_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [WORD_W-1:0] operand_in,
    input  logic [1:0]        pops_in,
    input  trap_e             cause_in,
    input  logic [WORD_W-1:0] rdata_in,
    output space_e            space_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [WORD_W-1:0] wdata,
    output logic [1:0]        pops_q,
    output trap_e             cause_q,
    output logic              cc_n,
    output logic              cc_z
);
    logic [WORD_W-1:0] operand_q;
    logic [WORD_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            space_q   <= SP_DATA;
            addr_q    <= '0;
            operand_q <= '0;
            pops_q    <= 2'd0;
            cause_q   <= TRAP_NONE;
        end else if (load_cmd) begin
            space_q   <= space_in;
            addr_q    <= addr_in;
            operand_q <= operand_in;
            pops_q    <= pops_in;
            cause_q   <= cause_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)          rdata_q <= '0;
        else if (load_rdata) rdata_q <= rdata_in;
    end

    assign wdata = operand_q & rdata_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cc_n <= 1'b0;
            cc_z <= 1'b0;
        end else if (commit) begin
            cc_n <= wdata[WORD_W-1];
            cc_z <= (wdata == '0);
        end
    end

    // R6
    cc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable({cc_n, cc_z}));
endmodule

// File: rtl/stkmem_and_unit.sv
module stkmem_and_unit
    import stkand_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic              priv_mode,
    input  logic [WORD_W-1:0] stk_a,
    input  logic [WORD_W-1:0] stk_b,
    input  logic [WORD_W-1:0] stk_c,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [1:0]        mem_space,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              done,
    output logic [1:0]        pop_cnt,
    output logic              trap,
    output logic [1:0]        trap_code,
    output logic              cc_n,
    output logic              cc_z
);
    logic              dec_legal;
    trap_e             dec_cause;
    space_e            dec_space;
    logic [ADDR_W-1:0] dec_addr;
    logic [WORD_W-1:0] dec_operand;
    logic [1:0]        dec_pops;
    logic              load_cmd;
    logic              load_rdata;
    logic              commit;
    space_e            space_q;
    logic [1:0]        pops_q;
    trap_e             cause_q;

    stkand_decode #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_decode (
        .op         (cmd_op),
        .priv       (priv_mode),
        .reg_a      (stk_a),
        .reg_b      (stk_b),
        .reg_c      (stk_c),
        .legal      (dec_legal),
        .trap_cause (dec_cause),
        .space      (dec_space),
        .addr       (dec_addr),
        .operand    (dec_operand),
        .pops       (dec_pops)
    );

    stkand_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .cmd_legal  (dec_legal),
        .trap_cause (dec_cause),
        .busy       (busy),
        .load_cmd   (load_cmd),
        .load_rdata (load_rdata),
        .commit     (commit),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .done       (done),
        .trap       (trap)
    );

    stkand_datapath #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_datapath (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_cmd   (load_cmd),
        .load_rdata (load_rdata),
        .commit     (commit),
        .space_in   (dec_space),
        .addr_in    (dec_addr),
        .operand_in (dec_operand),
        .pops_in    (dec_pops),
        .cause_in   (dec_cause),
        .rdata_in   (mem_rdata),
        .space_q    (space_q),
        .addr_q     (mem_addr),
        .wdata      (mem_wdata),
        .pops_q     (pops_q),
        .cause_q    (cause_q),
        .cc_n       (cc_n),
        .cc_z       (cc_z)
    );

    assign mem_space = space_q;
    assign pop_cnt   = done ? pops_q : 2'd0;
    assign trap_code = trap ? cause_q : TRAP_NONE;

    // R3
    priv_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd1 && !priv_mode) |=> (trap && trap_code == 2'd1));
    // R5
    align_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd2 && stk_a[0]) |=> (trap && trap_code == 2'd2));
    // R9
    op_none_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op == 2'd3) |=> !busy);
    // R8
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done || trap) |-> busy);
    // R4
    pop_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (pop_cnt == 2'd2 || pop_cnt == 2'd3));
endmodule

// File: tb/stkmem_and_unit_bench.sv
module stkmem_and_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        priv_mode = 1'b0;
    logic [15:0] stk_a = '0, stk_b = '0, stk_c = '0;
    logic        busy, mem_req, mem_we, done, trap, cc_n, cc_z;
    logic [1:0]  mem_space, pop_cnt, trap_code;
    logic [31:0] mem_addr;
    logic [15:0] mem_wdata;
    logic [15:0] mem_rdata;

    int checks = 0;
    int fails = 0;

    always #2 clk = ~clk;

    stkmem_and_unit u_stkmem_and_unit (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .priv_mode(priv_mode), .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c),
        .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_space(mem_space),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .done(done), .pop_cnt(pop_cnt), .trap(trap), .trap_code(trap_code),
        .cc_n(cc_n), .cc_z(cc_z)
    );

    // memory model: three spaces of 256 words
    logic [15:0] mem [0:2][0:255];
    logic        pre_we = 1'b0;
    logic [1:0]  pre_sp = '0;
    logic [7:0]  pre_idx = '0;
    logic [15:0] pre_data = '0;
    int          rd_cnt = 0;
    int          wr_cnt = 0;
    logic [31:0] last_rd_addr = '0;
    logic [1:0]  last_rd_sp = '0;

    function automatic logic [7:0] widx(input logic [1:0] sp, input logic [31:0] ad);
        return (sp == 2'd2) ? ad[8:1] : ad[7:0];
    endfunction

    always @(posedge clk) begin
        if (pre_we) mem[pre_sp][pre_idx] <= pre_data;
        if (mem_req && !mem_we) begin
            mem_rdata    <= mem[mem_space][widx(mem_space, mem_addr)];
            rd_cnt       <= rd_cnt + 1;
            last_rd_addr <= mem_addr;
            last_rd_sp   <= mem_space;
        end
        if (mem_req && mem_we) begin
            mem[mem_space][widx(mem_space, mem_addr)] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
        end
    end

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [1:0] sp, input logic [7:0] idx, input logic [15:0] d);
        @(negedge clk);
        pre_we = 1'b1; pre_sp = sp; pre_idx = idx; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    typedef struct packed {
        logic [1:0]  op;
        logic        priv;
        logic [15:0] a;
        logic [15:0] b;
        logic [15:0] c;
        logic [15:0] init;
        logic [15:0] res;
        logic [1:0]  pop;
        logic [1:0]  trp;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 16'h0010, 16'hF0F0, 16'h0000, 16'hFF00, 16'hF000, 2'd2, 2'd0}, // R1 negative
        '{2'd0, 1'b0, 16'h0020, 16'h00FF, 16'h0000, 16'hFF00, 16'h0000, 2'd2, 2'd0}, // R1 zero
        '{2'd1, 1'b1, 16'h0030, 16'h1234, 16'h0000, 16'h0FFF, 16'h0234, 2'd2, 2'd0}, // R2
        '{2'd1, 1'b0, 16'h0031, 16'hFFFF, 16'h0000, 16'h5555, 16'h5555, 2'd0, 2'd1}, // R3
        '{2'd2, 1'b0, 16'h0040, 16'h0000, 16'h8001, 16'hFFFF, 16'h8001, 2'd3, 2'd0}, // R4
        '{2'd2, 1'b1, 16'h0041, 16'h0000, 16'hFFFF, 16'hAAAA, 16'hAAAA, 2'd0, 2'd2}, // R5
        '{2'd2, 1'b1, 16'h0102, 16'h0000, 16'h00F0, 16'h0F0F, 16'h0000, 2'd3, 2'd0}, // R4 zero
        '{2'd0, 1'b1, 16'h00FF, 16'h7FFF, 16'h0000, 16'hFFFF, 16'h7FFF, 2'd2, 2'd0}, // R1 positive
        '{2'd2, 1'b0, 16'h0010, 16'h0003, 16'hFFFF, 16'h1357, 16'h1357, 2'd3, 2'd0}  // R4 high half
    };

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic exp_n, exp_z;
        exp_n = 1'b0; exp_z = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(!busy && !done && !trap, "R10 idle flags", {busy, done, trap}, 0);
        check(!mem_req, "R10 no request", mem_req, 0);
        check(pop_cnt == 0, "R10 pop_cnt", pop_cnt, 0);
        check({cc_n, cc_z} == 2'b00, "R10 cc", {cc_n, cc_z}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  sp;
            logic [31:0] ea;
            logic [7:0]  ix;
            int          rd0, wr0, cyc;
            logic        g_done, g_trap;
            logic [1:0]  g_pop, g_tc;
            sp = VECS[v].op;
            ea = (VECS[v].op == 2'd2) ? {VECS[v].b, VECS[v].a} : {16'h0, VECS[v].a};
            ix = widx(sp, ea);
            preload(sp, ix, VECS[v].init);
            rd0 = rd_cnt; wr0 = wr_cnt;
            cmd_valid = 1'b1; cmd_op = VECS[v].op; priv_mode = VECS[v].priv;
            stk_a = VECS[v].a; stk_b = VECS[v].b; stk_c = VECS[v].c;
            @(negedge clk);
            cmd_valid = 1'b0;
            cyc = 1;
            while (!(done || trap) && cyc < 10) begin
                @(negedge clk);
                cyc++;
            end
            g_done = done; g_trap = trap; g_pop = pop_cnt; g_tc = trap_code;
            if (VECS[v].trp == 2'd0) begin
                exp_n = VECS[v].res[15];
                exp_z = (VECS[v].res == 16'h0);
                check(g_done && cyc == 4, "R7 done latency", cyc, 4);
                check(g_pop == VECS[v].pop, (sp == 2'd2) ? "R4 pop" : "R1 pop", g_pop, VECS[v].pop);
                check(last_rd_addr == ea && last_rd_sp == sp, (sp == 2'd2) ? "R4 address" : "R1 address",
                      last_rd_addr, ea);
                check({cc_n, cc_z} == {exp_n, exp_z}, "R6 cc at done", {cc_n, cc_z}, {exp_n, exp_z});
            end else begin
                check(g_trap && cyc == 1 && g_tc == VECS[v].trp,
                      (VECS[v].trp == 2'd1) ? "R3 trap" : "R5 trap", {g_trap, g_tc}, {1'b1, VECS[v].trp});
                check(!g_done, "R3/R5 no done", g_done, 0);
                check({cc_n, cc_z} == {exp_n, exp_z}, "R6 cc held on trap", {cc_n, cc_z}, {exp_n, exp_z});
            end
            @(negedge clk);
            @(negedge clk);
            check(mem[sp][ix] == VECS[v].res, (VECS[v].op == 2'd1) ? "R2 memory" : "R1/R4 memory",
                  mem[sp][ix], VECS[v].res);
            check((rd_cnt - rd0) == ((VECS[v].trp == 0) ? 1 : 0) && (wr_cnt - wr0) == ((VECS[v].trp == 0) ? 1 : 0),
                  "R3/R5 access count", wr_cnt - wr0, (VECS[v].trp == 0) ? 1 : 0);
        end

        // R7 per-cycle sequence and R8 busy holdoff
        begin
            int wr0;
            preload(2'd0, 8'h50, 16'hFFFF);
            preload(2'd0, 8'h60, 16'hFFFF);
            wr0 = wr_cnt;
            cmd_valid = 1'b1; cmd_op = 2'd0; priv_mode = 1'b0;
            stk_a = 16'h0050; stk_b = 16'h0F0F; stk_c = 16'h0;
            @(negedge clk);
            stk_a = 16'h0060; stk_b = 16'h0000;
            check(busy && mem_req && !mem_we, "R7 read cycle", {busy, mem_req, mem_we}, 3'b110);
            @(negedge clk);
            check(busy && !mem_req, "R7 wait cycle", {busy, mem_req}, 2'b10);
            @(negedge clk);
            cmd_valid = 1'b0;
            check(busy && mem_req && mem_we && mem_wdata == 16'h0F0F, "R7 write cycle", mem_wdata, 16'h0F0F);
            @(negedge clk);
            check(done && busy, "R8 busy through done", {done, busy}, 2'b11);
            repeat (6) @(negedge clk);
            check(!busy && mem[0][8'h60] == 16'hFFFF && (wr_cnt - wr0) == 1, "R8 command ignored while busy",
                  mem[0][8'h60], 16'hFFFF);
            check(mem[0][8'h50] == 16'h0F0F, "R1 memory after holdoff", mem[0][8'h50], 16'h0F0F);
        end

        // R9 operation code 3 ignored
        begin
            int rd0;
            logic saw;
            rd0 = rd_cnt; saw = 1'b0;
            cmd_valid = 1'b1; cmd_op = 2'd3; stk_a = 16'h0010;
            @(negedge clk);
            cmd_valid = 1'b0;
            for (int k = 0; k < 5; k++) begin
                if (busy || trap || done || mem_req) saw = 1'b1;
                @(negedge clk);
            end
            check(!saw && rd_cnt == rd0, "R9 op3 ignored", saw, 0);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule